// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block is the receive-side byte buffer of a 16550-style serial port. Bytes and break indications arrive from a bit-level deserializer and go into a 16-entry first-in first-out store. A register bus drains the store through single-byte reads. A FIFO control byte written over the same bus selects buffered or single-register operation, requests flushes and picks the trigger level.

The block drives the receive status bits: data ready, overrun and break. It also drives a trigger-reached flag and a character-timeout flag, which a separate interrupt encoder consumes. The idle timeout is four character times. One character time is computed from a bit period in clock cycles and the current frame format: start bit, data length, optional parity and stop-bit count. With buffering off, the block acts as a single holding register.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: In buffered mode the trigger level comes from control bits 7:6: code 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. `trig_o` is high exactly when `fill_o` is at least that level.
- R2: A byte that arrives while the store holds 16 entries is dropped and `overrun_o` is set. The stored bytes still read out unchanged and in order.
- R3: A control write that flips the enable bit (bit 0) empties the receive store. For that write it also pulses `tx_flush_o` high for one cycle, one cycle after the write.
- R4: `fcr_o` keeps only bits 7, 6, 3 and 0 of a write and is 0x00 after reset. A write whose byte equals `fcr_o` changes nothing. Bit 2 set alone pulses `tx_flush_o` without touching the receive store.
- R5: A receive flush (bit 1 set in a write that changes state) empties the store, clears `break_o` and `timeout_o`, and cancels any running timeout.
- R6: In buffered mode, every received byte arms a countdown of 4 character times. So does every read that leaves data behind. `timeout_o` rises exactly that many cycles after the arming edge if the store is not empty; an empty store never raises it.
- R7: A receive read clears `timeout_o`. In buffered mode, `data_ready_o` and `break_o` drop only on the read that empties the store.
- R8: A break indication stores a 0x00 byte and sets both `break_o` and `data_ready_o`. A break arriving in the same cycle as a byte takes precedence.
- R9: A character time is `bit_cycles_i` × (1 + (5 + `word_sel_i`) + `parity_en_i` + (1 + `stop2_i`)) cycles.
- R10: In buffered mode, a read of an empty store returns 0x00 and leaves `fill_o` at 0.
- R11: With bit 0 of `fcr_o` clear, one holding register is used. `rd_data_o` shows the last byte received. A new byte while `data_ready_o` is high sets `overrun_o`, and a read clears `data_ready_o`.
- R12: A status read (`lsr_rd_i`) clears `overrun_o` and `break_o`. A new error in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_we_i | input | 1 | Control byte write strobe |
| fcr_wdata_i | input | 8 | Control byte |
| fcr_o | output | 8 | Retained control bits |
| tx_flush_o | output | 1 | One-cycle flush request for the transmit side |
| bit_cycles_i | input | BIT_W | Bit period in clock cycles |
| word_sel_i | input | 2 | Data length minus five |
| parity_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Second stop bit present |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | DW | Received byte |
| rx_break_i | input | 1 | Break received strobe |
| rd_i | input | 1 | Receive register read strobe |
| rd_data_o | output | DW | Receive register read data |
| lsr_rd_i | input | 1 | Line status read strobe |
| data_ready_o | output | 1 | Data ready status |
| overrun_o | output | 1 | Overrun status |
| break_o | output | 1 | Break status |
| trig_o | output | 1 | Trigger level reached |
| timeout_o | output | 1 | Character timeout pending |
| fill_o | output | $clog2(DEPTH+1) | Entries held in the store |

## Verification
The properties assume that strobes are single-cycle pulses, and that a byte strobe and a read strobe never name the same cycle as a control write they are meant to be checked against. The overrun and break properties therefore exclude cycles with a control write. The bench drives each strobe for exactly one clock and never overlaps a control write with receive traffic. It also holds the frame settings constant while a timeout measurement runs, so that the countdown length is the one loaded at the arming edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [7:0] FCR_KEEP  = 8'hC9;
  localparam int         FCR_EN    = 0;
  localparam int         FCR_RXRST = 1;
  localparam int         FCR_TXRST = 2;

  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_fcr.sv
module rxf_fcr
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] fcr_o,
  output logic       rx_rst_o,
  output logic       tx_flush_o
);
  logic [7:0] fcr_q;
  logic       flush_q;
  logic       changed;
  logic       en_flip;

  // equal write is a no-op: compare full byte with retained value
  assign changed  = we_i && (wdata_i != fcr_q);
  assign en_flip  = wdata_i[FCR_EN] ^ fcr_q[FCR_EN];
  assign rx_rst_o = changed && (wdata_i[FCR_RXRST] || en_flip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= changed && (wdata_i[FCR_TXRST] || en_flip);
      if (changed) fcr_q <= wdata_i & FCR_KEEP;
    end
  end

  assign fcr_o      = fcr_q;
  assign tx_flush_o = flush_q;
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full check uses pre-pop occupancy: no overwrite, no same-cycle slip
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && (wr_ptr_q == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
  parameter int BIT_W = 16,
  localparam int TW   = BIT_W + 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIT_W-1:0] bit_cycles_i,
  input  logic [1:0]       word_sel_i,
  input  logic             parity_i,
  input  logic             stop2_i,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic             ack_i,
  input  logic             has_data_i,
  output logic             flag_o
);
  logic [3:0]    frame;
  logic [TW-1:0] char_len;
  logic [TW-1:0] load;
  logic [TW-1:0] cnt_q;
  logic          flag_q;

  // start + (5+sel) data + parity + (1+stop2) stop
  assign frame    = 4'd7 + {2'b00, word_sel_i} + {3'b000, parity_i} + {3'b000, stop2_i};
  assign char_len = TW'(bit_cycles_i) * TW'(frame);
  assign load     = {char_len[TW-3:0], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cancel_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (arm_i)              cnt_q <= load;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (ack_i)              flag_q <= 1'b0;
      else if (!arm_i && cnt_q == TW'(1) && has_data_i) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int BIT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fcr_we_i,
  input  logic [7:0]                 fcr_wdata_i,
  output logic [7:0]                 fcr_o,
  output logic                       tx_flush_o,
  input  logic [BIT_W-1:0]           bit_cycles_i,
  input  logic [1:0]                 word_sel_i,
  input  logic                       parity_en_i,
  input  logic                       stop2_i,
  input  logic                       rx_valid_i,
  input  logic [DW-1:0]              rx_byte_i,
  input  logic                       rx_break_i,
  input  logic                       rd_i,
  output logic [DW-1:0]              rd_data_o,
  input  logic                       lsr_rd_i,
  output logic                       data_ready_o,
  output logic                       overrun_o,
  output logic                       break_o,
  output logic                       trig_o,
  output logic                       timeout_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_rst, fifo_en;
  logic          push_ev, st_push, st_pop, full, empty;
  logic          pop_empties, pop_leaves;
  logic [DW-1:0] push_byte, st_rdata, hold_q;
  logic [CW-1:0] count;
  logic          hold_dr_q, ovr_q, brk_q;
  logic          ovr_set, brk_clr, arm;

  rxf_fcr u_fcr (
    .clk_i, .rst_ni,
    .we_i       (fcr_we_i),
    .wdata_i    (fcr_wdata_i),
    .fcr_o      (fcr_o),
    .rx_rst_o   (rx_rst),
    .tx_flush_o (tx_flush_o)
  );

  assign fifo_en   = fcr_o[FCR_EN];
  assign push_ev   = rx_valid_i || rx_break_i;
  assign push_byte = rx_break_i ? '0 : rx_byte_i;
  assign st_push   = fifo_en && push_ev;
  assign st_pop    = fifo_en && rd_i && !empty;
  assign pop_empties = st_pop && !rx_rst && (count == CW'(1)) && !(st_push && !full);
  assign pop_leaves  = st_pop && !rx_rst && !pop_empties;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (rx_rst),
    .push_i  (st_push),
    .pop_i   (st_pop),
    .wdata_i (push_byte),
    .rdata_o (st_rdata),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  assign arm = fifo_en && !rx_rst && (push_ev || pop_leaves);

  rxf_timer #(.BIT_W(BIT_W)) u_timer (
    .clk_i, .rst_ni,
    .bit_cycles_i,
    .word_sel_i,
    .parity_i   (parity_en_i),
    .stop2_i,
    .arm_i      (arm),
    .cancel_i   (rx_rst),
    .ack_i      (rd_i),
    .has_data_i (!empty),
    .flag_o     (timeout_o)
  );

  // single holding register path (buffering off)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      hold_dr_q <= 1'b0;
    end else if (rx_rst) begin
      hold_dr_q <= 1'b0;
    end else if (!fifo_en && push_ev) begin
      hold_q    <= push_byte;
      hold_dr_q <= 1'b1;
    end else if (!fifo_en && rd_i) begin
      hold_dr_q <= 1'b0;
    end
  end

  assign ovr_set = !rx_rst && push_ev && (fifo_en ? full : (hold_dr_q && !rd_i));
  assign brk_clr = lsr_rd_i || rx_rst || (fifo_en ? pop_empties : rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (ovr_set)       ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
      if (!rx_rst && rx_break_i) brk_q <= 1'b1;
      else if (brk_clr)          brk_q <= 1'b0;
    end
  end

  assign rd_data_o    = fifo_en ? (empty ? '0 : st_rdata) : hold_q;
  assign data_ready_o = fifo_en ? !empty : hold_dr_q;
  assign trig_o       = fifo_en ? (count >= CW'(trig_level(fcr_o[7:6]))) : hold_dr_q;
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;
  assign fill_o       = count;
endmodule

// File: rtl/rx_fifo_ctrl_chk.sv
module rx_fifo_ctrl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fcr_we_i,
  input logic [7:0]    fcr_wdata_i,
  input logic [7:0]    fcr_o,
  input logic          tx_flush_o,
  input logic          rx_valid_i,
  input logic          rx_break_i,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          break_o,
  input logic          timeout_o,
  input logic [CW-1:0] fill_o
);
  // R2
  always_comb begin
    if (rst_ni) no_overflow_chk: assert (fill_o <= CW'(DEPTH));
  end

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[0] && fill_o == CW'(DEPTH) && rx_valid_i && !rd_i && !fcr_we_i)
      |=> (overrun_o && fill_o == CW'(DEPTH)));

  // R3
  en_flip_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[0] != fcr_o[0])
      |=> (tx_flush_o && fill_o == '0 && !timeout_o));

  // R4
  same_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i == fcr_o) |=> !tx_flush_o);

  // R7
  read_acks_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);

  // R6
  timeout_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);

  // R8
  break_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_i && !fcr_we_i) |=> (break_o && data_ready_o));

  // R10
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[0] && fill_o == '0 && rd_i && !rx_valid_i && !rx_break_i && !fcr_we_i)
      |-> (rd_data_o == '0) ##1 (fill_o == '0));
endmodule

bind rx_fifo_ctrl rx_fifo_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fcr_we_i     (fcr_we_i),
  .fcr_wdata_i  (fcr_wdata_i),
  .fcr_o        (fcr_o),
  .tx_flush_o   (tx_flush_o),
  .rx_valid_i   (rx_valid_i),
  .rx_break_i   (rx_break_i),
  .rd_i         (rd_i),
  .rd_data_o    (rd_data_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .break_o      (break_o),
  .timeout_o    (timeout_o),
  .fill_o       (fill_o)
);

// File: tb/rx_fifo_ctrl_bench.sv
module rx_fifo_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fcr_we_i = 1'b0;
  logic [7:0]  fcr_wdata_i = '0;
  logic [7:0]  fcr_o;
  logic        tx_flush_o;
  logic [15:0] bit_cycles_i = 16'd3;
  logic [1:0]  word_sel_i = 2'd3;
  logic        parity_en_i = 1'b0;
  logic        stop2_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_break_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        lsr_rd_i = 1'b0;
  logic        data_ready_o, overrun_o, break_o, trig_o, timeout_o;
  logic [4:0]  fill_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_ctrl u_rx_fifo_ctrl (
    .clk_i (clk), .rst_ni,
    .fcr_we_i, .fcr_wdata_i, .fcr_o, .tx_flush_o,
    .bit_cycles_i, .word_sel_i, .parity_en_i, .stop2_i,
    .rx_valid_i, .rx_byte_i, .rx_break_i,
    .rd_i, .rd_data_o, .lsr_rd_i,
    .data_ready_o, .overrun_o, .break_o, .trig_o, .timeout_o, .fill_o
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic fcr_write(input logic [7:0] v);
    fcr_we_i = 1'b1; fcr_wdata_i = v; step(); fcr_we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b; step(); rx_valid_i = 1'b0;
  endtask

  task automatic push_break();
    rx_break_i = 1'b1; step(); rx_break_i = 1'b0;
  endtask

  task automatic read(output logic [7:0] d);
    rd_i = 1'b1; d = rd_data_o; step(); rd_i = 1'b0;
  endtask

  task automatic lsr_read();
    lsr_rd_i = 1'b1; step(); lsr_rd_i = 1'b0;
  endtask

  function automatic int lvl_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  function automatic int char_cycles(input int bc, input int sel, input int par, input int st);
    return bc * (1 + 5 + sel + par + 1 + st);
  endfunction

  task automatic wait_timeout(output int n);
    n = 0;
    while (!timeout_o && n < 4000) begin step(); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n, lim;
    step(); step();
    rst_ni = 1'b1;
    step();

    check("R4", "reset fcr", fcr_o, 0);
    check("R11", "reset ready", data_ready_o, 0);
    check("R10", "reset fill", fill_o, 0);
    check("R6", "reset timeout", timeout_o, 0);

    // holding register mode
    push(8'h5A);
    check("R11", "hold ready", data_ready_o, 1);
    check("R11", "hold data", rd_data_o, 8'h5A);
    check("R11", "hold no ovr", overrun_o, 0);
    push(8'hA5);
    check("R11", "hold overrun", overrun_o, 1);
    check("R11", "hold newest", rd_data_o, 8'hA5);
    read(d);
    check("R11", "hold read data", d, 8'hA5);
    check("R11", "hold ready cleared", data_ready_o, 0);
    lsr_read();
    check("R12", "overrun cleared", overrun_o, 0);

    // enable buffering
    fcr_write(8'hC7);
    check("R4", "retained mask", fcr_o, 8'hC1);
    check("R3", "flush pulse", tx_flush_o, 1);
    step();
    check("R3", "flush one cycle", tx_flush_o, 0);

    // trigger level and full sweep
    bit_cycles_i = 16'd200;
    for (int code = 0; code < 4; code++) begin
      fcr_write(8'(code << 6) | 8'h03);
      check("R4", "code retained", fcr_o, (code << 6) | 1);
      check("R5", "flush empties", fill_o, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        push(8'(k * 7 + code));
        check("R1", $sformatf("fill code %0d", code), fill_o, k);
        check("R1", $sformatf("trig code %0d k %0d", code, k), trig_o, int'(k >= lvl_of(code)));
      end
      check("R2", "no ovr at full", overrun_o, 0);
      push(8'hEE);
      check("R2", "overrun on full", overrun_o, 1);
      check("R2", "fill held", fill_o, DEPTH);
      for (int k = 1; k <= DEPTH; k++) begin
        read(d);
        check("R2", $sformatf("order k %0d", k), d, (k * 7 + code) & 8'hFF);
        check("R7", "ready until empty", data_ready_o, int'(k < DEPTH));
      end
      read(d);
      check("R10", "empty read data", d, 0);
      check("R10", "empty read fill", fill_o, 0);
      lsr_read();
      check("R12", "overrun cleared", overrun_o, 0);
    end

    // timeout length sweep over all frame formats
    bit_cycles_i = 16'd3;
    for (int cfg = 0; cfg < 16; cfg++) begin
      word_sel_i  = 2'(cfg & 3);
      parity_en_i = cfg[2];
      stop2_i     = cfg[3];
      fcr_write((cfg[0]) ? 8'h03 : 8'h43);
      push(8'(cfg));
      wait_timeout(n);
      lim = 4 * char_cycles(3, cfg & 3, cfg[2], cfg[3]);
      check("R9", $sformatf("timeout cycles cfg %0d", cfg), n, lim);
    end
    // cfg 15 remains: sel 3, parity, 2 stops
    lim = 4 * char_cycles(3, 3, 1, 1);
    check("R6", "timeout raised", timeout_o, 1);
    push(8'h77);
    check("R6", "push keeps flag", timeout_o, 1);
    read(d);
    check("R7", "read clears timeout", timeout_o, 0);
    check("R7", "ready kept", data_ready_o, 1);
    wait_timeout(n);
    check("R6", "rearm after read", n, lim);
    read(d);
    check("R7", "last read data", d, 8'h77);
    check("R7", "ready cleared", data_ready_o, 0);
    for (int i = 0; i < lim + 5; i++) step();
    check("R6", "no timeout when empty", timeout_o, 0);

    // flush cancels a running countdown
    push(8'h11);
    for (int i = 0; i < lim / 2; i++) step();
    fcr_write(8'h03);
    check("R5", "flush fill", fill_o, 0);
    check("R5", "flush ready", data_ready_o, 0);
    for (int i = 0; i < lim + 5; i++) step();
    check("R5", "countdown cancelled", timeout_o, 0);
    push(8'h12);
    wait_timeout(n);
    fcr_write(8'h03);
    check("R5", "flush clears flag", timeout_o, 0);

    // break handling
    push_break();
    check("R8", "break flag", break_o, 1);
    check("R8", "break ready", data_ready_o, 1);
    check("R8", "break byte stored", fill_o, 1);
    push(8'h33);
    read(d);
    check("R8", "break byte zero", d, 0);
    check("R7", "break held while data", break_o, 1);
    read(d);
    check("R7", "byte after break", d, 8'h33);
    check("R7", "break cleared on empty", break_o, 0);
    rx_valid_i = 1'b1; rx_byte_i = 8'h99; rx_break_i = 1'b1; step();
    rx_valid_i = 1'b0; rx_break_i = 1'b0;
    read(d);
    check("R8", "break wins over byte", d, 0);
    push_break();
    lsr_read();
    check("R12", "status read clears break", break_o, 0);
    check("R12", "data kept", data_ready_o, 1);

    // equal write and transmit-only flush
    fcr_write(8'h01);
    check("R4", "equal write fill", fill_o, 1);
    check("R4", "equal write no flush", tx_flush_o, 0);
    fcr_write(8'h05);
    check("R4", "tx only flush", tx_flush_o, 1);
    check("R4", "tx flush keeps rx", fill_o, 1);
    check("R4", "tx flush retained", fcr_o, 8'h01);

    // disable buffering
    fcr_write(8'h00);
    check("R3", "disable flush", tx_flush_o, 1);
    check("R3", "disable empties", fill_o, 0);
    check("R3", "disable ready", data_ready_o, 0);
    check("R3", "disable fcr", fcr_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule